// File: doc/BRIEF.md
# Strobed Serial Register Access Port

This block lets a slow host reach a bank of six 8-bit peripheral registers over a handful of wires: a data line, a strobe line, an enable line, two select lines and a read/write line. The data, strobe and enable lines are brought into the system clock domain through two-stage synchronisers. Edges are detected on the synchronised copies. An internal 8-bit shifter sits between the wires and the bank.

For a write, the host puts the select and read/write lines in place. It shifts eight bits in, least significant first, on rising strobe edges. It then gives one LOW pulse on enable: the falling edge copies the shifter into the selected register. A write to the transmit register also raises a one-cycle transmit-start pulse on the rising edge of that same enable pulse. For a read, a first LOW enable pulse loads the selected register into the shifter on its rising edge. A second LOW pulse puts the port in shift-out mode, with bit 0 already on the data output. Seven more rising strobe edges present bits 1 to 7. Loading the status register for a read raises a one-cycle clear pulse for its owner.

The controller is a three-state machine. IDLE (the write state) takes serial bits and commits them. LOADED holds a read word that is not yet on the wire. SHIFT drives the data line. The transitions are:
- IDLE to LOADED on an enable rise while reading.
- LOADED to SHIFT on the next enable rise.
- SHIFT to LOADED on a further enable rise, which reloads the word.
- LOADED or SHIFT back to IDLE whenever read/write returns to write.

Top module: `serial_reg_port`

## Requirements
- R1: Select decoding, with sel[0] as the first select bit and sel[1] as the second. For a write, sel=00 is clock configuration, 01 is UART configuration, 10 is UART transmit and 11 is port extension. For a read, sel=00 returns the receive input, 01 returns the status input, and 10 and 11 return zero.
- R2: Write bits enter on synchronised rising strobe edges, least significant bit first. After eight strobes, the falling edge of a LOW enable pulse with rd=0 commits the word to the register picked by R1.
- R3: A register changes only through a commit. Strobe activity alone, or a commit to another register, leaves it unchanged.
- R4: After reset, the UART configuration, transmit and extension registers are zero. The clock configuration equals CLK_CFG_RST (default 0x00, meaning card clock stopped LOW and slowest system clock). All six extension pins are HIGH and data_oe is LOW.
- R5: The extension pins show the bitwise inverse of bits 5..0 of the stored extension word. Bits 7..6 of a write to it have no effect.
- R6: A read uses two enable pulses. The rising edge of the first loads the selected word. After the rising edge of the second, data_oe is HIGH and data_o shows bit 0. Each further rising strobe edge advances data_o by one bit, up to bit 7.
- R7: The load pulse of a status read (rd=1, sel=01) raises status_clr_o for exactly one cycle. A receive read raises no pulse.
- R8: A commit to the transmit register causes a one-cycle tx_start_o pulse on the following enable rise. Commits to other registers cause none.
- R9: data_oe falls when rd returns to 0, or when a new load pulse arrives during shift-out.
- R10: After only the first read pulse, data_oe stays LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Host shift strobe |
| enable_i | input | 1 | Host enable, active-LOW pulses |
| sel_i | input | 2 | Register select lines |
| rd_i | input | 1 | 1 = read, 0 = write |
| data_i | input | 1 | Serial data from host |
| data_o | output | 1 | Serial data to host |
| data_oe | output | 1 | Drive enable for data_o |
| clk_cfg_o | output | 8 | Clock configuration register |
| uart_cfg_o | output | 8 | UART configuration register |
| tx_data_o | output | 8 | UART transmit register |
| tx_start_o | output | 1 | Transmit-start pulse |
| ext_pins_o | output | 6 | Inverted extension outputs |
| rx_data_i | input | 8 | Received character to read |
| status_i | input | 8 | UART status word to read |
| status_clr_o | output | 1 | Status clear-on-read pulse |

## Verification
The assertions take for granted that sel_i and rd_i are quasi-static. They must be settled several system clocks before any enable edge and held through the access. Every strobe, enable and data level must also last longer than the synchroniser latency, so that no edge is lost or merged. The bench drives all host lines on falling clock edges. It holds each level for four system clocks, and it changes select and read/write only while enable is HIGH and the line is idle.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_SHIFT  = 2'd2
    } port_state_t;

    localparam logic [1:0] SEL_CLK  = 2'b00;
    localparam logic [1:0] SEL_UCFG = 2'b01;
    localparam logic [1:0] SEL_TX   = 2'b10;
    localparam logic [1:0] SEL_EXT  = 2'b11;
    localparam logic [1:0] SEL_RX   = 2'b00;
    localparam logic [1:0] SEL_STAT = 2'b01;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[g] <= rst_val;
                else if (g == 0)
                    stage_q[g] <= async_i;
                else
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift_in,
    input  logic          in_bit,
    input  logic          shift_out,
    output logic [DW-1:0] word_o,
    output logic          lsb_o
);
    logic [DW-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= load_val;
        else if (shift_in)
            sr_q <= {in_bit, sr_q[DW-1:1]};
        else if (shift_out)
            sr_q <= {1'b0, sr_q[DW-1:1]};
    end

    assign word_o = sr_q;
    assign lsb_o  = sr_q[0];

    // R6
    shifter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_in && !shift_out) |=> $stable(sr_q))
        else $error("shifter changed without a command");
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank
    import srp_pkg::*;
#(
    parameter int          DW          = 8,
    parameter int          EXT_W       = 6,
    parameter logic [DW-1:0] CLK_CFG_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] clk_cfg,
    output logic [DW-1:0] uart_cfg,
    output logic [DW-1:0] tx_data,
    output logic [EXT_W-1:0] ext_pins
);
    logic [EXT_W-1:0] ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_cfg  <= CLK_CFG_RST;
            uart_cfg <= '0;
            tx_data  <= '0;
            ext_q    <= '0;
        end else if (commit) begin
            unique case (sel)
                SEL_CLK:  clk_cfg  <= wdata;
                SEL_UCFG: uart_cfg <= wdata;
                SEL_TX:   tx_data  <= wdata;
                SEL_EXT:  ext_q    <= wdata[EXT_W-1:0];
            endcase
        end
    end

    assign ext_pins = ~ext_q;

    always_comb begin
        unique case (sel)
            SEL_RX:   rdata = rx_data;
            SEL_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(clk_cfg) && $stable(uart_cfg) && $stable(tx_data) && $stable(ext_pins)))
        else $error("register changed without commit");
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_rise,
    input  logic       en_fall,
    input  logic       st_rise,
    input  logic       rd,
    input  logic [1:0] sel,
    output logic       load,
    output logic       shift_in,
    output logic       shift_out,
    output logic       commit,
    output logic       drive,
    output logic       status_clr,
    output logic       tx_kick
);
    port_state_t state_q, state_d;
    logic        tx_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tx_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (commit && sel == SEL_TX)
                tx_pend_q <= 1'b1;
            else if (tx_kick)
                tx_pend_q <= 1'b0;
        end
    end

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        shift_in  = 1'b0;
        shift_out = 1'b0;
        commit    = 1'b0;
        drive     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd && en_rise) begin
                    load    = 1'b1;
                    state_d = ST_LOADED;
                end
                if (!rd && en_fall)
                    commit = 1'b1;
                if (!rd && st_rise)
                    shift_in = 1'b1;
            end
            ST_LOADED: begin
                if (!rd)
                    state_d = ST_IDLE;
                else if (en_rise)
                    state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                drive = 1'b1;
                if (!rd)
                    state_d = ST_IDLE;
                else if (en_rise) begin
                    load    = 1'b1;
                    state_d = ST_LOADED;
                end else if (st_rise)
                    shift_out = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        status_clr = load && sel == SEL_STAT;
        tx_kick    = tx_pend_q && en_rise && !rd;
    end

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !drive)
        else $error("data driven in write mode");
    // R10
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(en_rise))
        else $error("drive began without mode pulse");
    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> !status_clr)
        else $error("status clear longer than one cycle");
    // R8
    kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |=> !tx_kick)
        else $error("transmit start longer than one cycle");
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
    parameter int         DW          = 8,
    parameter int         EXT_W       = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CLK_CFG_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             enable_i,
    input  logic [1:0]       sel_i,
    input  logic             rd_i,
    input  logic             data_i,
    output logic             data_o,
    output logic             data_oe,
    output logic [DW-1:0]    clk_cfg_o,
    output logic [DW-1:0]    uart_cfg_o,
    output logic [DW-1:0]    tx_data_o,
    output logic             tx_start_o,
    output logic [EXT_W-1:0] ext_pins_o,
    input  logic [DW-1:0]    rx_data_i,
    input  logic [DW-1:0]    status_i,
    output logic             status_clr_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_s;
    logic [1:0]       prev_q;
    logic             st_s, en_s, dat_s;
    logic             st_rise, en_rise, en_fall;
    logic             load, shift_in, shift_out, commit;
    logic [DW-1:0]    sr_word, rdata;

    srp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({data_i, enable_i, strobe_i}),
        .rst_val ({1'b1, 1'b1, 1'b1}),
        .sync_o  (sync_s)
    );

    assign st_s  = sync_s[0];
    assign en_s  = sync_s[1];
    assign dat_s = sync_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 2'b11;
        else
            prev_q <= {en_s, st_s};
    end

    assign st_rise = st_s & ~prev_q[0];
    assign en_rise = en_s & ~prev_q[1];
    assign en_fall = ~en_s & prev_q[1];

    srp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rise    (en_rise),
        .en_fall    (en_fall),
        .st_rise    (st_rise),
        .rd         (rd_i),
        .sel        (sel_i),
        .load       (load),
        .shift_in   (shift_in),
        .shift_out  (shift_out),
        .commit     (commit),
        .drive      (data_oe),
        .status_clr (status_clr_o),
        .tx_kick    (tx_start_o)
    );

    srp_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (rdata),
        .shift_in  (shift_in),
        .in_bit    (dat_s),
        .shift_out (shift_out),
        .word_o    (sr_word),
        .lsb_o     (data_o)
    );

    srp_regbank #(.DW(DW), .EXT_W(EXT_W), .CLK_CFG_RST(CLK_CFG_RST)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .sel      (sel_i),
        .wdata    (sr_word),
        .rx_data  (rx_data_i),
        .status   (status_i),
        .rdata    (rdata),
        .clk_cfg  (clk_cfg_o),
        .uart_cfg (uart_cfg_o),
        .tx_data  (tx_data_o),
        .ext_pins (ext_pins_o)
    );

    // R4
    ext_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ext_pins_o == '1))
        else $error("extension pins not high after reset");
    // R9
    load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && en_rise && rd_i) |=> !data_oe)
        else $error("data still driven after new load pulse");
endmodule

// File: tb/tb_serial_reg_port.sv
`timescale 1ns/1ps
module tb_serial_reg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b1, enable = 1'b1, rd = 1'b0, din = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [7:0] rx_data = 8'h00, status = 8'h00;
    logic dout, doe, tx_start, status_clr;
    logic [7:0] clk_cfg, uart_cfg, tx_data;
    logic [5:0] ext_pins;

    int n_checks = 0, n_fail = 0, kick_cnt = 0, clr_cnt = 0, cycles = 0;

    always #4 clk = ~clk;

    serial_reg_port dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .enable_i(enable),
        .sel_i(sel), .rd_i(rd), .data_i(din), .data_o(dout), .data_oe(doe),
        .clk_cfg_o(clk_cfg), .uart_cfg_o(uart_cfg), .tx_data_o(tx_data),
        .tx_start_o(tx_start), .ext_pins_o(ext_pins), .rx_data_i(rx_data),
        .status_i(status), .status_clr_o(status_clr)
    );

    always @(negedge clk) begin
        if (tx_start) kick_cnt++;
        if (status_clr) clr_cnt++;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_enable();
        enable = 1'b0; hold();
        enable = 1'b1; hold();
    endtask

    task automatic pulse_strobe();
        strobe = 1'b0; hold();
        strobe = 1'b1; hold();
    endtask

    task automatic write_reg(logic [1:0] s, logic [7:0] v);
        rd = 1'b0; sel = s; hold();
        for (int i = 0; i < 8; i++) begin
            din = v[i];
            pulse_strobe();
        end
        din = 1'b1;
        pulse_enable();
    endtask

    task automatic read_reg(logic [1:0] s, string tag, output logic [7:0] v);
        rd = 1'b1; sel = s; hold();
        pulse_enable();
        chk({tag, " R10 oe after first pulse"}, doe, 1'b0);
        pulse_enable();
        chk({tag, " R6 oe after second pulse"}, doe, 1'b1);
        v[0] = dout;
        for (int i = 1; i < 8; i++) begin
            pulse_strobe();
            v[i] = dout;
        end
    endtask

    task automatic t_reset();
        chk("R4 clk_cfg", clk_cfg, 8'h00);
        chk("R4 uart_cfg", uart_cfg, 8'h00);
        chk("R4 tx_data", tx_data, 8'h00);
        chk("R4 ext_pins", ext_pins, 6'h3F);
        chk("R4 data_oe", doe, 1'b0);
    endtask

    task automatic t_writes();
        int k0;
        k0 = kick_cnt;
        write_reg(2'b00, 8'hA5);
        chk("R1 R2 clk_cfg write", clk_cfg, 8'hA5);
        write_reg(2'b01, 8'h3C);
        chk("R1 uart_cfg write", uart_cfg, 8'h3C);
        chk("R3 clk_cfg kept", clk_cfg, 8'hA5);
        chk("R8 no kick on cfg writes", kick_cnt, k0);
        write_reg(2'b10, 8'h5A);
        chk("R1 tx_data write", tx_data, 8'h5A);
        chk("R8 one kick on tx write", kick_cnt, k0 + 1);
        write_reg(2'b11, 8'hC3);
        chk("R5 ext pins inverted", ext_pins, 6'h3C);
        chk("R8 no kick on ext write", kick_cnt, k0 + 1);
        write_reg(2'b11, 8'h3F);
        chk("R5 ext all driven low", ext_pins, 6'h00);
        write_reg(2'b11, 8'hC0);
        chk("R5 upper bits ignored", ext_pins, 6'h3F);
        write_reg(2'b00, 8'h01);
        chk("R2 lsb first", clk_cfg, 8'h01);
    endtask

    task automatic t_strobe_only();
        rd = 1'b0; sel = 2'b01;
        for (int i = 0; i < 8; i++) begin
            din = i[0];
            pulse_strobe();
        end
        chk("R3 uart_cfg no commit", uart_cfg, 8'h3C);
        chk("R3 tx_data no commit", tx_data, 8'h5A);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        int c0;
        c0 = clr_cnt;
        rx_data = 8'h96;
        read_reg(2'b00, "rx", v);
        chk("R6 rx read value", v, 8'h96);
        chk("R7 no clear on rx read", clr_cnt, c0);
        rd = 1'b0; hold();
        chk("R9 release on write", doe, 1'b0);
        status = 8'h81;
        read_reg(2'b01, "stat", v);
        chk("R6 status read value", v, 8'h81);
        chk("R7 clear pulse once", clr_cnt, c0 + 1);
        pulse_enable();
        chk("R9 release on new load", doe, 1'b0);
        rd = 1'b0; hold();
        read_reg(2'b10, "unused", v);
        chk("R1 unused read is zero", v, 8'h00);
        rd = 1'b0; hold();
        chk("R3 regs kept after reads", {clk_cfg, uart_cfg}, {8'h01, 8'h3C});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        hold();
        t_reset();
        t_writes();
        t_strobe_only();
        t_reads();
        summary();
    end
endmodule